// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for one display pipe. A horizontal counter runs once per pixel clock and a vertical counter steps once per line. Both are compared against positions held in registers to produce horizontal and vertical sync, horizontal and vertical blank, and a data-active strobe. Every line and every frame begins at the leading edge of sync, at count zero. The blank edges and the addressable window are explicit register positions, so software places the borders and porches wherever the target mode needs them.

The pixel path takes the incoming pixel and replaces it where the raster calls for that. Positions inside the visible area but outside the addressable window get a programmable overscan colour. Positions in blank give zero. A forced-blank control bit replaces every pixel with a programmable black colour.

A single-cycle write port loads the settings. The timing parameters go into a pending copy, which the counters adopt only at the start of a frame, or at once while the generator is stopped. A small read port returns the vertical-blank status, the live counter position, a frame count and the control word. Software is expected to keep the horizontal blank at 56 pixels or more and each horizontal porch at 4 pixels or more. The block does not check these limits.

Top module: `disp_raster_gen`

## Requirements
- R1: Write address 0 holds horizontal total minus one and address 1 holds vertical total minus one, each in bits [11:0]. While running, the horizontal counter counts 0 up to that value and then returns to 0. The vertical counter steps only when the horizontal counter returns to 0, and it wraps in the same way.
- R2: Address 4 holds the horizontal sync end and address 5 the vertical sync end. The raw sync on each axis is asserted for counts from 0 up to, but not including, its end value.
- R3: Control bit 2 sets the horizontal sync polarity and bit 3 the vertical sync polarity. The value 0 drives the raw sync as active high, and 1 inverts it to active low.
- R4: Address 2 holds the horizontal blank start in bits [27:16] and the blank end in bits [11:0]. Address 3 holds the same two fields for vertical. An axis is visible for counts at or above blank end and below blank start. `hblank` and `vblank` are the inverse of visible, and `data_active` is high only when both axes are visible. `pix_out` is zero whenever either axis is in blank.
- R5: Address 6 holds the horizontal addressable window, with the exclusive end in bits [27:16] and the start in bits [11:0]. Address 7 holds the vertical window in the same layout. Inside the visible area, `pix_out` equals `pix_in` within both windows and equals the overscan colour (address 10) elsewhere.
- R6: While control bit 1 (force black) is set, `pix_out` equals the black colour (address 9) at every position. Colours are packed as {R/Cr[23:16], G/Y[15:8], B/Cb[7:0]}.
- R7: The frame counter increments by one at the edge where both counters wrap together to position (0,0).
- R8: Read address 0 returns vertical blank in bit 0. Read address 1 returns the vertical count in [27:16] and the horizontal count in [11:0]. Read address 2 returns the frame counter. Read address 3 returns the control word, where bit 4 is the stored interlace enable.
- R9: Control bit 0 is the master enable. While it is clear, both counters and the frame counter hold their values.
- R10: Writes to addresses 0 to 7 land in a pending copy. The copy becomes active on the edge that starts a new frame, or on any edge while the master enable is clear. A frame in progress keeps its old totals.
- R11: After reset, all registers and counters are zero. The block is therefore stopped at position (0,0) with both axes in blank, both syncs low and `pix_out` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Read port address |
| rd_data | output | 32 | Read port data |
| pix_in | input | 24 | Incoming pixel {R,G,B} |
| pix_out | output | 24 | Outgoing pixel {R,G,B} |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| hblank | output | 1 | Horizontal blank |
| vblank | output | 1 | Vertical blank |
| data_active | output | 1 | Both axes visible |

## Verification
The hardest case to reach from the ports is a change to the totals written in the middle of a running frame. The new values must be held back until the wrap to (0,0) and must then apply at once. The bench writes a shorter horizontal total halfway through a line, confirms that the counter still passes the old limit in that frame, then waits for the frame start and counts cycles to show that the line has become shorter. Border positions are reached by polling the position register until the counter stands on each target pixel. Output checks then sample on the falling edge at that exact count.

// File: rtl/disp_raster_gen.sv
module disp_raster_gen #(
  parameter int CW  = 12,
  parameter int CDW = 8,
  parameter int FCW = 16,
  parameter int AW  = 4,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic [3*CDW-1:0]  pix_in,
  output logic [3*CDW-1:0]  pix_out,
  output logic              hsync,
  output logic              vsync,
  output logic              hblank,
  output logic              vblank,
  output logic              data_active
);
  localparam int PW  = 3 * CDW;
  localparam int NT  = 12;
  localparam int HI  = DW / 2;
  localparam int PAD = HI - CW;

  localparam int HT  = 0;
  localparam int VT  = 1;
  localparam int HBE = 2;
  localparam int HBS = 3;
  localparam int VBE = 4;
  localparam int VBS = 5;
  localparam int HSE = 6;
  localparam int VSE = 7;
  localparam int HAS = 8;
  localparam int HAE = 9;
  localparam int VAS = 10;
  localparam int VAE = 11;

  logic [CW-1:0]  pend [NT];
  logic [CW-1:0]  tm   [NT];
  logic [4:0]     ctrl;
  logic [PW-1:0]  blk_col, ovs_col;
  logic [CW-1:0]  h_cnt, v_cnt;
  logic [FCW-1:0] frame;

  wire run        = ctrl[0];
  wire force_blk  = ctrl[1];
  wire h_last     = h_cnt >= tm[HT];
  wire v_last     = v_cnt >= tm[VT];
  wire frame_wrap = run && h_last && v_last;

  // register write port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) pend[i] <= '0;
      ctrl    <= '0;
      blk_col <= '0;
      ovs_col <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        4'd0: pend[HT] <= wr_data[CW-1:0];
        4'd1: pend[VT] <= wr_data[CW-1:0];
        4'd2: begin pend[HBE] <= wr_data[CW-1:0]; pend[HBS] <= wr_data[HI +: CW]; end
        4'd3: begin pend[VBE] <= wr_data[CW-1:0]; pend[VBS] <= wr_data[HI +: CW]; end
        4'd4: pend[HSE] <= wr_data[CW-1:0];
        4'd5: pend[VSE] <= wr_data[CW-1:0];
        4'd6: begin pend[HAS] <= wr_data[CW-1:0]; pend[HAE] <= wr_data[HI +: CW]; end
        4'd7: begin pend[VAS] <= wr_data[CW-1:0]; pend[VAE] <= wr_data[HI +: CW]; end
        4'd8: ctrl    <= wr_data[4:0];
        4'd9: blk_col <= wr_data[PW-1:0];
        4'd10: ovs_col <= wr_data[PW-1:0];
        default: ;
      endcase
    end
  end

  // active timing set: loaded at frame start or while stopped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) tm[i] <= '0;
    end else if (!run || frame_wrap) begin
      for (int i = 0; i < NT; i++) tm[i] <= pend[i];
    end
  end

  // raster counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt <= '0;
      v_cnt <= '0;
      frame <= '0;
    end else if (run) begin
      h_cnt <= h_last ? '0 : CW'(h_cnt + 1'b1);
      if (h_last) v_cnt <= v_last ? '0 : CW'(v_cnt + 1'b1);
      if (frame_wrap) frame <= FCW'(frame + 1'b1);
    end
  end

  wire h_vis  = (h_cnt >= tm[HBE]) && (h_cnt < tm[HBS]);
  wire v_vis  = (v_cnt >= tm[VBE]) && (v_cnt < tm[VBS]);
  wire h_addr = (h_cnt >= tm[HAS]) && (h_cnt < tm[HAE]);
  wire v_addr = (v_cnt >= tm[VAS]) && (v_cnt < tm[VAE]);

  assign hsync       = (h_cnt < tm[HSE]) ^ ctrl[2];
  assign vsync       = (v_cnt < tm[VSE]) ^ ctrl[3];
  assign hblank      = !h_vis;
  assign vblank      = !v_vis;
  assign data_active = h_vis && v_vis;

  assign pix_out = force_blk            ? blk_col :
                   !data_active         ? '0      :
                   (h_addr && v_addr)   ? pix_in  : ovs_col;

  // read port
  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = DW'(vblank);
      2'd1:    rd_data = {{PAD{1'b0}}, v_cnt, {PAD{1'b0}}, h_cnt};
      2'd2:    rd_data = DW'(frame);
      default: rd_data = DW'(ctrl);
    endcase
  end

  assert_h_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && h_cnt >= tm[HT]) |=> (h_cnt == '0))
    else $error("horizontal counter did not wrap");

  assert_hold_when_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(h_cnt) && $stable(v_cnt) && $stable(frame)))
    else $error("counters moved while stopped");

  assert_frame_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && h_cnt >= tm[HT] && v_cnt >= tm[VT]) |=> (frame == FCW'($past(frame) + 1'b1)))
    else $error("frame counter did not step");

  assert_no_midframe_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(h_cnt >= tm[HT] && v_cnt >= tm[VT])) |=> ($stable(tm[HT]) && $stable(tm[VT])))
    else $error("timing changed inside a frame");

  assert_v_steps_on_h_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && h_cnt < tm[HT]) |=> $stable(v_cnt))
    else $error("vertical counter moved mid-line");
endmodule

// File: tb/disp_raster_gen_test.sv
`timescale 1ns/1ps
module disp_raster_gen_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [23:0] pix_in = 24'hA1B2C3;
  logic [23:0] pix_out;
  logic        hsync, vsync, hblank, vblank, data_active;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  localparam logic [23:0] PIX = 24'hA1B2C3;
  localparam logic [23:0] OVS = 24'h112233;
  localparam logic [23:0] BLK = 24'h445566;

  // {h[52:41], v[40:29], hs,vs,hbl,vbl,act [28:24], pix[23:0]}
  localparam logic [52:0] VEC [12] = '{
    {12'd3,  12'd0,  5'b11110, 24'h0},
    {12'd8,  12'd1,  5'b01110, 24'h0},
    {12'd58, 12'd5,  5'b00001, OVS},
    {12'd70, 12'd7,  5'b00001, PIX},
    {12'd59, 12'd7,  5'b00001, OVS},
    {12'd92, 12'd8,  5'b00001, OVS},
    {12'd93, 12'd11, 5'b00001, OVS},
    {12'd91, 12'd11, 5'b00001, PIX},
    {12'd94, 12'd8,  5'b00100, 24'h0},
    {12'd70, 12'd12, 5'b00001, OVS},
    {12'd70, 12'd13, 5'b00010, 24'h0},
    {12'd57, 12'd7,  5'b00100, 24'h0}
  };

  disp_raster_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pix_in(pix_in), .pix_out(pix_out),
    .hsync(hsync), .vsync(vsync), .hblank(hblank), .vblank(vblank),
    .data_active(data_active)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_addr = a;
    wr_data = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_pos(input int h, input int v);
    bit hit = 0;
    rd_addr = 2'd1;
    for (int n = 0; n < 4000 && !hit; n++) begin
      @(negedge clk);
      if (rd_data == {4'd0, 12'(v), 4'd0, 12'(h)}) hit = 1;
    end
    if (!hit) chk("R1 position reached", 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R11 reset state
    rd_addr = 2'd1; #1; chk("R11 position", rd_data, 32'h0);
    rd_addr = 2'd2; #1; chk("R11 frame", rd_data, 32'h0);
    rd_addr = 2'd0; #1; chk("R11 vblank status", rd_data, 32'h1);
    chk("R11 pixel", {8'h0, pix_out}, 32'h0);
    chk("R11 syncs/active", {29'h0, hsync, vsync, data_active}, 32'h0);
    @(negedge clk);

    wr(4'd0, 32'd99);
    wr(4'd1, 32'd13);
    wr(4'd2, {16'd94, 16'd58});
    wr(4'd3, {16'd13, 16'd5});
    wr(4'd4, 32'd8);
    wr(4'd5, 32'd2);
    wr(4'd6, {16'd92, 16'd60});
    wr(4'd7, {16'd12, 16'd6});
    wr(4'd9, {8'h0, BLK});
    wr(4'd10, {8'h0, OVS});
    wr(4'd8, 32'h1);

    // R2 R4 R5 vector table
    for (int i = 0; i < 12; i++) begin
      wait_pos(int'(VEC[i][52:41]), int'(VEC[i][40:29]));
      chk("R2 R4 flags", {27'h0, hsync, vsync, hblank, vblank, data_active},
          {27'h0, VEC[i][28:24]});
      chk("R4 R5 pixel", {8'h0, pix_out}, {8'h0, VEC[i][23:0]});
    end

    // R3 polarity
    wr(4'd8, 32'hD);
    wait_pos(3, 0);
    chk("R3 inverted syncs during sync", {30'h0, hsync, vsync}, 32'h0);
    wait_pos(20, 5);
    chk("R3 inverted syncs outside sync", {30'h0, hsync, vsync}, 32'h3);
    wr(4'd8, 32'h1);

    // R6 force black
    wr(4'd8, 32'h3);
    wait_pos(70, 7);
    chk("R6 black in addressable", {8'h0, pix_out}, {8'h0, BLK});
    wait_pos(94, 8);
    chk("R6 black in blank", {8'h0, pix_out}, {8'h0, BLK});
    wr(4'd8, 32'h1);

    // R7 frame counter
    wait_pos(50, 3);
    rd_addr = 2'd2; #1; a = rd_data;
    wait_pos(50, 3);
    rd_addr = 2'd2; #1; b = rd_data;
    chk("R7 frame step", b, a + 1);

    // R8 status and readback
    wait_pos(20, 2);
    rd_addr = 2'd0; #1; chk("R8 vblank set", rd_data, 32'h1);
    wait_pos(20, 6);
    rd_addr = 2'd0; #1; chk("R8 vblank clear", rd_data, 32'h0);
    @(negedge clk);
    wr(4'd8, 32'h11);
    rd_addr = 2'd3; #1; chk("R8 interlace readback", rd_data, 32'h11);
    @(negedge clk);
    wr(4'd8, 32'h1);

    // R9 stop
    wr(4'd8, 32'h0);
    rd_addr = 2'd1; #1; a = rd_data;
    repeat (20) @(negedge clk);
    rd_addr = 2'd1; #1; b = rd_data;
    chk("R9 position held", b, a);
    @(negedge clk);
    wr(4'd8, 32'h1);

    // R10 shadowed totals
    wait_pos(50, 7);
    wr(4'd0, 32'd79);
    repeat (39) @(negedge clk);
    rd_addr = 2'd1; #1;
    chk("R10 old total kept mid-frame", rd_data, {16'd7, 16'd90});
    wait_pos(0, 0);
    repeat (85) @(negedge clk);
    rd_addr = 2'd1; #1;
    chk("R10 new total after frame start", rd_data, {16'd1, 16'd5});
    @(negedge clk);
    wr(4'd0, 32'd99);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule